// File: doc/BRIEF.md
# Nibble-Serial Link Transmit Buffer

This block takes parallel words from a DMA engine or a processor write port and sends them out over a narrow link. The link has three signals: a clock strobe, a 4-bit data bus and an acknowledge returned by the receiver. Incoming words wait in a two-slot queue. One slot is a staging register that takes the written word. The other is an unpacking register that shifts the word out one nibble at a time, most significant nibble first.

Each buffer has a width select. A word is either 32 bits, sent as 8 nibbles, or 48 bits, sent as 12 nibbles. The 48-bit setting is the one to use for 40-bit extended data and for 48-bit instruction words. The block asks for more data whenever a slot is free and reports how many words it holds. It starts a new word only while the receiver acknowledges, so a receiver that is not yet enabled holds the sender off. Dropping the enable empties the queue and clears the status.

Top module: `nib_link_tx`

## Requirements
- R1: After reset with `enable` low, `bufStat` is 00, `dmaReq` is 0, and `linkClk` and `linkDat` are both 0.
- R2: A write (`wrValid` high at a rising clock edge while `enable` is high) is accepted unless two words are already held. Two accepted words that have not yet drained make the buffer full. A write offered while full is dropped and is never transmitted.
- R3: `bufStat` gives the number of words held, counting the word being sent. The encoding is 00 for empty, 01 for one word and 10 for full. It updates at the clock edge that accepts a write or finishes the last nibble of a word.
- R4: `dmaReq` is high exactly while `enable` is high and the buffer is not full.
- R5: Each word is sent most significant nibble first. In 48-bit mode the first nibble is `wrData[47:44]`. In 32-bit mode the first nibble is `wrData[31:28]`, and `wrData[47:32]` is ignored.
- R6: Each nibble takes two clock cycles: one cycle with `linkClk` high, then one cycle with `linkClk` low. `linkDat` changes only in the cycle where `linkClk` rises, so it is stable across the falling edge.
- R7: While no word is being sent, `linkClk` stays low and `linkDat` stays 0. This includes the empty buffer.
- R8: `linkAck` is looked at only between words. A held word starts only in a cycle where `linkAck` is high. Once a word has started, it runs to its last nibble whatever `linkAck` does.
- R9: When `enable` is low at a clock edge, the buffer becomes empty, any word in flight is abandoned, `linkClk` returns low, and writes at that edge are ignored.
- R10: The width (`wideMode` high = 48 bits / 12 nibbles, low = 32 bits / 8 nibbles) is taken for each word when that word enters the unpacking register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Buffer enable; low clears the queue |
| wideMode | input | 1 | 1 = 48-bit words, 0 = 32-bit words |
| wrValid | input | 1 | Write strobe from the DMA or core port |
| wrData | input | 48 | Word to send (32-bit words use bits 31:0) |
| dmaReq | output | 1 | A slot is free and the buffer is enabled |
| linkClk | output | 1 | Link clock strobe, high phase first for each nibble |
| linkDat | output | 4 | Link nibble data |
| linkAck | input | 1 | Receiver acknowledge; gates the start of each word |
| bufStat | output | 2 | Fill status: 00 empty, 01 one word, 10 full |

## Verification
The assertions place no limits on `linkAck` or on when writes arrive. Writes offered while full, acknowledge dropping mid-word, and `enable` falling during a transfer are all legal, and the properties are written to hold under them. The falling-edge stability check assumes only that a strobe drop coming from a disable is excused, since that drop forces the data to zero. The stimulus changes inputs only on the falling clock edge, and it changes `wideMode` only while the buffer is empty, so each word's width is unambiguous for the reference model.

// File: rtl/nib_link_tx_pkg.sv
package nib_link_tx_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;       // drop all held data
    logic loadStage;   // capture write word into staging register
    logic moveUnpack;  // staging word moves into the unpacking register
    logic moveWide;    // width applied to the moving word
    logic shiftNib;    // advance the unpacking register by one nibble
  } tx_strobe_t;

  typedef enum logic [1:0] {
    BUF_EMPTY = 2'b00,
    BUF_ONE   = 2'b01,
    BUF_FULL  = 2'b10
  } buf_stat_e;
endpackage

// File: rtl/nib_link_tx_dp.sv
module nib_link_tx_dp
  import nib_link_tx_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int WIDE_NIBS   = 12,
  parameter int NARROW_NIBS = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  tx_strobe_t                      strobe,
  input  logic [NIB_W*WIDE_NIBS-1:0]      wrData,
  output logic [NIB_W-1:0]                headNib
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WORD_W   = NIB_W * WIDE_NIBS;
  localparam int NARROW_W = NIB_W * NARROW_NIBS;
  localparam int PAD_W    = WORD_W - NARROW_W;

  logic [WORD_W-1:0] stgWord;
  logic [WORD_W-1:0] unpReg;
  logic [WORD_W-1:0] alignedWord;

  // narrow words are left-aligned so the top nibble is always sent first
  always_comb begin
    if (strobe.moveWide) alignedWord = stgWord;
    else                 alignedWord = {stgWord[NARROW_W-1:0], {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgWord <= '0;
      unpReg  <= '0;
    end else if (strobe.clear) begin
      stgWord <= '0;
      unpReg  <= '0;
    end else begin
      if (strobe.loadStage) stgWord <= wrData;
      if (strobe.moveUnpack)    unpReg <= alignedWord;
      else if (strobe.shiftNib) unpReg <= {unpReg[WORD_W-NIB_W-1:0], {NIB_W{1'b0}}};
    end
  end

  assign headNib = unpReg[WORD_W-1 -: NIB_W];

  // a move and a shift never coincide: the move only follows the last nibble
  p_move_shift_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.moveUnpack && strobe.shiftNib));
endmodule

// File: rtl/nib_link_tx_ctrl.sv
module nib_link_tx_ctrl
  import nib_link_tx_pkg::*;
#(
  parameter int WIDE_NIBS   = 12,
  parameter int NARROW_NIBS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       wideMode,
  input  logic       wrValid,
  input  logic       linkAck,
  output tx_strobe_t strobe,
  output logic       nibValid,
  output logic       linkClk,
  output logic       dmaReq,
  output logic [1:0] bufStat
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W = $clog2(WIDE_NIBS);
  localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WIDE_NIBS - 1);
  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_NIBS - 1);

  logic             stgValid, unpValid, unpWide;
  logic             sending, lowPhase;
  logic [CNT_W-1:0] nibIdx;

  logic full, lastNib, finishing, moveWord, wrAcc, startWord;

  always_comb begin
    full      = stgValid & unpValid;
    lastNib   = (nibIdx == '0);
    finishing = sending & lowPhase & lastNib;
    moveWord  = stgValid & (~unpValid | finishing);
    wrAcc     = enable & wrValid & ~full;
    startWord = enable & unpValid & ~sending & linkAck;

    strobe.clear      = ~enable;
    strobe.loadStage  = wrAcc;
    strobe.moveUnpack = enable & moveWord;
    strobe.moveWide   = wideMode;
    strobe.shiftNib   = enable & sending & lowPhase & ~lastNib;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgValid <= 1'b0;
      unpValid <= 1'b0;
      unpWide  <= 1'b0;
      sending  <= 1'b0;
      lowPhase <= 1'b0;
      nibIdx   <= '0;
    end else if (!enable) begin
      stgValid <= 1'b0;
      unpValid <= 1'b0;
      unpWide  <= 1'b0;
      sending  <= 1'b0;
      lowPhase <= 1'b0;
      nibIdx   <= '0;
    end else begin
      stgValid <= wrAcc | (stgValid & ~moveWord);
      if (moveWord) begin
        unpValid <= 1'b1;
        unpWide  <= wideMode;
      end else if (finishing) begin
        unpValid <= 1'b0;
      end
      if (startWord) begin
        sending  <= 1'b1;
        lowPhase <= 1'b0;
        nibIdx   <= unpWide ? WIDE_LAST : NARROW_LAST;
      end else if (sending) begin
        if (!lowPhase) begin
          lowPhase <= 1'b1;
        end else if (lastNib) begin
          sending  <= 1'b0;
          lowPhase <= 1'b0;
        end else begin
          lowPhase <= 1'b0;
          nibIdx   <= nibIdx - 1'b1;
        end
      end
    end
  end

  always_comb begin
    nibValid = sending;
    linkClk  = sending & ~lowPhase;
    dmaReq   = enable & ~full;
    if (full)                       bufStat = BUF_FULL;
    else if (stgValid | unpValid)   bufStat = BUF_ONE;
    else                            bufStat = BUF_EMPTY;
  end

  // a full buffer stays full until a word completes
  p_full_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && full && !finishing) |=> full);

  // no word starts at a boundary without acknowledge
  p_hold_no_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !sending && !linkAck) |=> !sending);

  // a started word keeps running regardless of acknowledge
  p_word_runs_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && sending && !finishing) |=> sending);

  // disable empties everything
  p_clear_on_disable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!stgValid && !unpValid && !sending));
endmodule

// File: rtl/nib_link_tx.sv
module nib_link_tx
  import nib_link_tx_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int WIDE_NIBS   = 12,
  parameter int NARROW_NIBS = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       enable,
  input  logic                       wideMode,
  input  logic                       wrValid,
  input  logic [NIB_W*WIDE_NIBS-1:0] wrData,
  output logic                       dmaReq,
  output logic                       linkClk,
  output logic [NIB_W-1:0]           linkDat,
  input  logic                       linkAck,
  output logic [1:0]                 bufStat
);
  timeunit 1ns;
  timeprecision 1ps;

  tx_strobe_t       strobe;
  logic             nibValid;
  logic [NIB_W-1:0] headNib;

  nib_link_tx_ctrl #(
    .WIDE_NIBS  (WIDE_NIBS),
    .NARROW_NIBS(NARROW_NIBS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .wideMode(wideMode),
    .wrValid (wrValid),
    .linkAck (linkAck),
    .strobe  (strobe),
    .nibValid(nibValid),
    .linkClk (linkClk),
    .dmaReq  (dmaReq),
    .bufStat (bufStat)
  );

  nib_link_tx_dp #(
    .NIB_W      (NIB_W),
    .WIDE_NIBS  (WIDE_NIBS),
    .NARROW_NIBS(NARROW_NIBS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .headNib(headNib)
  );

  assign linkDat = nibValid ? headNib : '0;

  // empty buffer means a silent link
  p_idle_when_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bufStat == BUF_EMPTY) |-> (!linkClk && linkDat == '0));

  // data holds across the falling strobe edge (a disable may abort it)
  p_nib_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(linkClk) && $past(enable)) |-> $stable(linkDat));
endmodule

// File: tb/nib_link_tx_bench.sv
module nib_link_tx_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        wideMode = 1'b1;
  logic        wrValid = 1'b0;
  logic [47:0] wrData = '0;
  logic        linkAck = 1'b0;
  logic        dmaReq, linkClk;
  logic [3:0]  linkDat;
  logic [1:0]  bufStat;

  always #4 clk = ~clk;

  nib_link_tx u_nib_link_tx (
    .clk(clk), .rstN(rstN), .enable(enable), .wideMode(wideMode),
    .wrValid(wrValid), .wrData(wrData), .dmaReq(dmaReq),
    .linkClk(linkClk), .linkDat(linkDat), .linkAck(linkAck), .bufStat(bufStat)
  );

  int nChk = 0, nFail = 0, cyc = 0, riseCnt = 0;
  bit done = 0, prevClk = 0;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: queue of held words, nibble queue of the word on the wire
  logic [47:0] q[$];
  logic [3:0]  cur[$];
  bit mSend, mPhase, headReady, headWide;
  int mSz;
  bit mFin, mAcc, mSt, newReady;

  always @(posedge clk) begin
    if (!rstN || !enable) begin
      q.delete(); cur.delete();
      mSend = 0; mPhase = 0; headReady = 0; headWide = 0;
    end else begin
      mSz  = q.size();
      mFin = mSend && mPhase && cur.size() == 1;
      mAcc = wrValid && mSz < 2;
      mSt  = !mSend && headReady && linkAck;
      newReady = headReady;
      if (mSt) begin
        cur.delete();
        for (int i = 0; i < (headWide ? 12 : 8); i++)
          cur.push_back(4'((q[0] >> (4 * ((headWide ? 12 : 8) - 1 - i))) & 48'hF));
        mSend = 1; mPhase = 0;
      end else if (mSend) begin
        if (!mPhase) mPhase = 1;
        else begin
          void'(cur.pop_front());
          mPhase = 0;
          if (cur.size() == 0) begin
            mSend = 0;
            void'(q.pop_front());
            newReady = 0;
          end
        end
      end
      if (mFin && q.size() >= 1) begin newReady = 1; headWide = wideMode; end
      else if (!headReady && mSz >= 1) begin newReady = 1; headWide = wideMode; end
      headReady = newReady;
      if (mAcc) q.push_back(wrData);
    end
    #2;
    cyc++;
    if (rstN) begin
      check("R6", "linkClk", linkClk, longint'(mSend && !mPhase));
      check(mSend ? "R5" : "R7", "linkDat", linkDat, mSend ? longint'(cur[0]) : 0);
      check("R3", "bufStat", bufStat, q.size());
      check("R4", "dmaReq", dmaReq, longint'(enable && q.size() < 2));
      if (linkClk && !prevClk) riseCnt++;
      prevClk = linkClk;
    end
    if (cyc > 60000 && !done) begin
      done = 1;
      nChk++; nFail++;
      $display("FAIL watchdog actual %0d expected below 60000", cyc);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic putWord(input logic [47:0] d);
    @(negedge clk);
    wrValid = 1; wrData = d;
    @(negedge clk);
    wrValid = 0;
  endtask

  task automatic putWhenReady(input logic [47:0] d);
    @(negedge clk);
    while (!dmaReq) @(negedge clk);
    wrValid = 1; wrData = d;
    @(negedge clk);
    wrValid = 0;
  endtask

  initial begin
    idle(3);
    rstN = 1;
    idle(2);
    // R1: reset state
    check("R1", "bufStat", bufStat, 0);
    check("R1", "dmaReq", dmaReq, 0);
    check("R1", "linkClk", linkClk, 0);
    check("R1", "linkDat", linkDat, 0);

    // R2/R8: fill with acknowledge withheld, third write dropped
    enable = 1;
    @(negedge clk);
    check("R4", "dmaReq enabled empty", dmaReq, 1);
    riseCnt = 0;
    putWord(48'h123456789ABC);
    putWord(48'hFEDCBA987654);
    putWord(48'h0F0F0F0F0F0F);
    idle(20);
    check("R2", "bufStat full", bufStat, 2);
    check("R8", "no strobe without ack", riseCnt, 0);
    linkAck = 1;
    idle(80);
    check("R2", "only two words sent", riseCnt, 24);
    check("R5", "drained", bufStat, 0);

    // R10: narrow word, upper bits ignored
    wideMode = 0;
    riseCnt = 0;
    putWord(48'hAAAA_CAFEF00D);
    idle(40);
    check("R10", "narrow nibble count", riseCnt, 8);

    // R8: ack drop mid-word, word completes; next word waits
    wideMode = 1;
    riseCnt = 0;
    putWord(48'h5A5A5A5A5A5A);
    while (!linkClk) @(negedge clk);
    idle(3);
    linkAck = 0;
    idle(40);
    check("R8", "word completes after ack drop", riseCnt, 12);
    riseCnt = 0;
    putWord(48'h111122223333);
    idle(20);
    check("R8", "held at boundary", riseCnt, 0);
    check("R8", "word still held", bufStat, 1);
    linkAck = 1;
    idle(40);

    // stream with writes paced by dmaReq
    for (int i = 0; i < 6; i++) putWhenReady(48'h0123_4567_89AB ^ (48'h1111_1111_1111 * 48'(i)));
    idle(200);
    check("R5", "stream drained", bufStat, 0);

    // R9: disable in mid-transfer with a write offered
    putWord(48'hDEADBEEF1234);
    putWord(48'h9876543210FE);
    idle(4);
    enable = 0; wrValid = 1; wrData = 48'hBADBADBADBAD;
    @(negedge clk);
    wrValid = 0;
    check("R9", "bufStat cleared", bufStat, 0);
    check("R9", "linkClk low", linkClk, 0);
    check("R9", "linkDat zero", linkDat, 0);
    check("R9", "dmaReq low", dmaReq, 0);
    enable = 1;
    idle(3);
    check("R9", "write while disabled ignored", bufStat, 0);
    idle(5);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule